// File: doc/BRIEF.md
# Logical Device Address Decoder and Signal Router

This block sits between an ISA-style expansion bus and up to five logical devices on one card. It takes each device's configuration as static inputs and turns bus activity into per-device selects. The configuration covers an active flag, an I/O base and block-size code, an interrupt level, a DMA channel and, for the first two devices, a memory window. From the same configuration it routes each device's interrupt request onto one of eleven bus interrupt lines. It also connects the DMA request and acknowledge of two devices to configurable bus DMA pins, translating through a table that records which physical bus channel is wired to each pin.

A mode input selects between two layouts. The narrow layout has two devices with memory windows, three DMA pins and one output enable. The wide layout has five I/O-only devices, five DMA pins and two output enables. Every output is registered. Each output shows the decode of the inputs sampled at the previous rising clock edge, and all outputs are low while reset is held.

Top module: `ldr_router`

## Requirements
- R1: Device d's I/O select asserts when address bits 15..n equal its I/O base bits 15..n, where n is its 3-bit size code (0 to 6, giving a block of 2^n bytes). Size code 7 never selects.
- R2: While the address-enable input is high, no I/O select and no output enable asserts.
- R3: In the narrow layout (mode 0), the memory select of device 0 or 1 asserts when address bits 23..8 lie between its base and its upper limit, both bounds included.
- R4: In the wide layout (mode 1), no memory select asserts. Devices 2, 3 and 4 decode I/O like devices 0 and 1.
- R5: A device's 4-bit interrupt level L drives one bus interrupt line with the level of the device's interrupt input. Levels 3,4,5,6,7,9,10,11,12,14,15 map to isaIrq bits 0 to 10 in that order. Any other level drives no line. Lines shared by several devices are ORed.
- R6: A device whose active bit is 0 asserts no I/O select, memory select, interrupt line, DMA pin request, acknowledge or output enable.
- R7: For devices 0 and 1, a DMA channel of 4 means no DMA. Otherwise the device request drives every enabled pin whose 3-bit map entry equals the channel, and the device acknowledge is the OR of those pins' acknowledge inputs.
- R8: Output enable k asserts while the read strobe is high and the I/O select of the device named by its 3-bit code is asserted. In mode 1, codes 0 to 4 name devices 0 to 4. In mode 0, codes 0 and 1 name devices 0 and 1, code 2 names either of them, and output enable 1 stays low. Any other code enables nothing.
- R9: In mode 0, devices 2 to 4 and DMA pins 3 and 4 are ignored entirely.
- R10: Outputs are all 0 during reset. After reset, each output reflects the inputs present at the previous rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| modeSel | input | 1 | 0: two devices with memory; 1: five I/O-only devices |
| devActive | input | 5 | Per-device active flag |
| ioBase | input | 80 | I/O base, 16 bits per device |
| ioSizeCode | input | 15 | I/O block-size code, 3 bits per device |
| irqLevel | input | 20 | Interrupt level, 4 bits per device |
| dmaChan | input | 6 | DMA channel of devices 0 and 1, 3 bits each |
| memBase | input | 32 | Memory base bits 23..8 of devices 0 and 1 |
| memLimit | input | 32 | Memory upper limit bits 23..8 of devices 0 and 1 |
| oenSel0 | input | 3 | Device code for output enable 0 |
| oenSel1 | input | 3 | Device code for output enable 1 |
| dmaMap | input | 15 | Bus channel wired to each DMA pin, 3 bits per pin |
| busAddr | input | 24 | Bus address |
| busAen | input | 1 | Address enable (high during DMA) |
| busIoRd | input | 1 | I/O read strobe, active high |
| devIntr | input | 5 | Device interrupt requests |
| devDrq | input | 2 | DMA requests of devices 0 and 1 |
| pinDack | input | 5 | Bus DMA acknowledge per pin, active high |
| ioSel | output | 5 | I/O select per device |
| memSel | output | 2 | Memory select of devices 0 and 1 |
| oenOut | output | 2 | Output enables |
| isaIrq | output | 11 | Bus interrupt lines |
| pinDrq | output | 5 | Bus DMA request per pin |
| devDack | output | 2 | DMA acknowledge to devices 0 and 1 |

## Verification
The bench targets addresses one byte inside and one byte outside each block size. A design that masks one bit too many or too few would then select a neighbour block or miss the last byte. It also sweeps the memory window at both bounds and one step past them, which catches strict or swapped comparisons. All sixteen interrupt levels are tried, so a shifted line table or a decode of levels 8 or 13 would light the wrong line. Channel 4 and duplicated map entries are driven to expose a router that treats 4 as a real channel or stops at the first match. Mode 0 is driven with busy devices 2 to 4 to show leakage from the wide layout.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  parameter int NUM_DEV = 5;
  parameter int MEM_DEV = 2;
  parameter int DMA_DEV = 2;
  parameter int NUM_PIN = 5;
  parameter int M0_DEV  = 2;
  parameter int M0_PIN  = 3;
  parameter int IO_AW   = 16;
  parameter int MEM_AW  = 24;
  parameter int MEM_LSB = 8;
  parameter int NUM_IRQ = 11;
  parameter int SZ_W    = 3;
  parameter int IRQ_W   = 4;
  parameter int CH_W    = 3;
  parameter int OEN_W   = 3;

  localparam int MEM_CW = MEM_AW - MEM_LSB;
  localparam logic [SZ_W-1:0] SZ_NONE = '1;
  localparam logic [CH_W-1:0] NO_DMA  = CH_W'(4);

  typedef struct packed {
    logic [NUM_DEV-1:0] devEn;
    logic [NUM_PIN-1:0] pinEn;
    logic [MEM_DEV-1:0] memEn;
    logic               oen1En;
    logic               modeWide;
  } strobes_t;

  function automatic logic [IRQ_W-1:0] irqLevelOf(input int k);
    int lvl;
    if (k < 5)      lvl = k + 3;
    else if (k < 9) lvl = k + 4;
    else            lvl = k + 5;
    return IRQ_W'(lvl);
  endfunction
endpackage

// File: rtl/ldr_ctrl.sv
module ldr_ctrl
  import ldr_pkg::*;
(
  input  logic               modeSel,
  input  logic [NUM_DEV-1:0] devActive,
  output strobes_t           strb
);
  always_comb begin
    strb = '0;
    strb.modeWide = modeSel;
    strb.oen1En   = modeSel;
    for (int d = 0; d < NUM_DEV; d++)
      strb.devEn[d] = devActive[d] && (modeSel || d < M0_DEV);
    for (int p = 0; p < NUM_PIN; p++)
      strb.pinEn[p] = modeSel || p < M0_PIN;
    for (int d = 0; d < MEM_DEV; d++)
      strb.memEn[d] = devActive[d] && !modeSel;
  end
endmodule

// File: rtl/ldr_datapath.sv
module ldr_datapath
  import ldr_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  strobes_t                  strb,
  input  logic [NUM_DEV*IO_AW-1:0]  ioBase,
  input  logic [NUM_DEV*SZ_W-1:0]   ioSizeCode,
  input  logic [NUM_DEV*IRQ_W-1:0]  irqLevel,
  input  logic [DMA_DEV*CH_W-1:0]   dmaChan,
  input  logic [MEM_DEV*MEM_CW-1:0] memBase,
  input  logic [MEM_DEV*MEM_CW-1:0] memLimit,
  input  logic [OEN_W-1:0]          oenSel0,
  input  logic [OEN_W-1:0]          oenSel1,
  input  logic [NUM_PIN*CH_W-1:0]   dmaMap,
  input  logic [MEM_AW-1:0]         busAddr,
  input  logic                      busAen,
  input  logic                      busIoRd,
  input  logic [NUM_DEV-1:0]        devIntr,
  input  logic [DMA_DEV-1:0]        devDrq,
  input  logic [NUM_PIN-1:0]        pinDack,
  output logic [NUM_DEV-1:0]        ioSel,
  output logic [MEM_DEV-1:0]        memSel,
  output logic [1:0]                oenOut,
  output logic [NUM_IRQ-1:0]        isaIrq,
  output logic [NUM_PIN-1:0]        pinDrq,
  output logic [DMA_DEV-1:0]        devDack
);
  logic [NUM_DEV-1:0] ioHit;
  logic [MEM_DEV-1:0] memHit;
  logic [1:0]         oenHit;
  logic [NUM_IRQ-1:0] irqHit;
  logic [NUM_PIN-1:0] drqHit;
  logic [DMA_DEV-1:0] dackHit;

  function automatic logic oenPick(input logic [OEN_W-1:0] code, input logic wide,
                                   input logic [NUM_DEV-1:0] hits);
    logic r;
    r = 1'b0;
    if (wide) begin
      for (int d = 0; d < NUM_DEV; d++)
        if (code == OEN_W'(d)) r = hits[d];
    end else begin
      for (int d = 0; d < M0_DEV; d++)
        if (code == OEN_W'(d) || code == OEN_W'(M0_DEV)) r = r | hits[d];
    end
    return r;
  endfunction

  always_comb begin
    logic [SZ_W-1:0]  code;
    logic [IO_AW-1:0] mask;
    for (int d = 0; d < NUM_DEV; d++) begin
      code     = ioSizeCode[d*SZ_W +: SZ_W];
      mask     = {IO_AW{1'b1}} << code;
      ioHit[d] = strb.devEn[d] && !busAen && (code != SZ_NONE) &&
                 (((busAddr[IO_AW-1:0] ^ ioBase[d*IO_AW +: IO_AW]) & mask) == '0);
    end
  end

  always_comb begin
    for (int d = 0; d < MEM_DEV; d++)
      memHit[d] = strb.memEn[d] &&
                  (busAddr[MEM_AW-1:MEM_LSB] >= memBase[d*MEM_CW +: MEM_CW]) &&
                  (busAddr[MEM_AW-1:MEM_LSB] <= memLimit[d*MEM_CW +: MEM_CW]);
  end

  always_comb begin
    oenHit[0] = busIoRd && oenPick(oenSel0, strb.modeWide, ioHit);
    oenHit[1] = busIoRd && strb.oen1En && oenPick(oenSel1, strb.modeWide, ioHit);
  end

  always_comb begin
    irqHit = '0;
    for (int k = 0; k < NUM_IRQ; k++)
      for (int d = 0; d < NUM_DEV; d++)
        if (strb.devEn[d] && irqLevel[d*IRQ_W +: IRQ_W] == irqLevelOf(k))
          irqHit[k] = irqHit[k] | devIntr[d];
  end

  always_comb begin
    logic [CH_W-1:0] chan;
    drqHit  = '0;
    dackHit = '0;
    for (int d = 0; d < DMA_DEV; d++) begin
      chan = dmaChan[d*CH_W +: CH_W];
      for (int p = 0; p < NUM_PIN; p++)
        if (strb.devEn[d] && strb.pinEn[p] && chan != NO_DMA &&
            dmaMap[p*CH_W +: CH_W] == chan) begin
          drqHit[p]  = drqHit[p] | devDrq[d];
          dackHit[d] = dackHit[d] | pinDack[p];
        end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ioSel   <= '0;
      memSel  <= '0;
      oenOut  <= '0;
      isaIrq  <= '0;
      pinDrq  <= '0;
      devDack <= '0;
    end else begin
      ioSel   <= ioHit;
      memSel  <= memHit;
      oenOut  <= oenHit;
      isaIrq  <= irqHit;
      pinDrq  <= drqHit;
      devDack <= dackHit;
    end
  end

  AST_AEN_BLOCKS_IO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busAen) |-> (ioSel == '0 && oenOut == '0)); // R2
  AST_INACTIVE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ioSel & ~$past(strb.devEn)) == '0); // R6
  AST_WIDE_NO_MEM: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strb.modeWide) |-> memSel == '0); // R4
  AST_OEN_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (|oenOut) |-> $past(busIoRd)); // R8
  AST_DACK_FROM_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    (|devDack) |-> (|$past(pinDack))); // R7
  AST_NARROW_PINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(strb.modeWide) |-> (pinDrq[NUM_PIN-1:M0_PIN] == '0 && !oenOut[1])); // R9
endmodule

// File: rtl/ldr_router.sv
module ldr_router
  import ldr_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      modeSel,
  input  logic [NUM_DEV-1:0]        devActive,
  input  logic [NUM_DEV*IO_AW-1:0]  ioBase,
  input  logic [NUM_DEV*SZ_W-1:0]   ioSizeCode,
  input  logic [NUM_DEV*IRQ_W-1:0]  irqLevel,
  input  logic [DMA_DEV*CH_W-1:0]   dmaChan,
  input  logic [MEM_DEV*MEM_CW-1:0] memBase,
  input  logic [MEM_DEV*MEM_CW-1:0] memLimit,
  input  logic [OEN_W-1:0]          oenSel0,
  input  logic [OEN_W-1:0]          oenSel1,
  input  logic [NUM_PIN*CH_W-1:0]   dmaMap,
  input  logic [MEM_AW-1:0]         busAddr,
  input  logic                      busAen,
  input  logic                      busIoRd,
  input  logic [NUM_DEV-1:0]        devIntr,
  input  logic [DMA_DEV-1:0]        devDrq,
  input  logic [NUM_PIN-1:0]        pinDack,
  output logic [NUM_DEV-1:0]        ioSel,
  output logic [MEM_DEV-1:0]        memSel,
  output logic [1:0]                oenOut,
  output logic [NUM_IRQ-1:0]        isaIrq,
  output logic [NUM_PIN-1:0]        pinDrq,
  output logic [DMA_DEV-1:0]        devDack
);
  strobes_t strb;

  ldr_ctrl u_ctrl (
    .modeSel  (modeSel),
    .devActive(devActive),
    .strb     (strb)
  );

  ldr_datapath u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .ioBase    (ioBase),
    .ioSizeCode(ioSizeCode),
    .irqLevel  (irqLevel),
    .dmaChan   (dmaChan),
    .memBase   (memBase),
    .memLimit  (memLimit),
    .oenSel0   (oenSel0),
    .oenSel1   (oenSel1),
    .dmaMap    (dmaMap),
    .busAddr   (busAddr),
    .busAen    (busAen),
    .busIoRd   (busIoRd),
    .devIntr   (devIntr),
    .devDrq    (devDrq),
    .pinDack   (pinDack),
    .ioSel     (ioSel),
    .memSel    (memSel),
    .oenOut    (oenOut),
    .isaIrq    (isaIrq),
    .pinDrq    (pinDrq),
    .devDack   (devDack)
  );
endmodule

// File: tb/ldr_router_test.sv
module ldr_router_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic modeSel;
  logic [4:0]  devActive;
  logic [79:0] ioBase;
  logic [14:0] ioSizeCode;
  logic [19:0] irqLevel;
  logic [5:0]  dmaChan;
  logic [31:0] memBase, memLimit;
  logic [2:0]  oenSel0, oenSel1;
  logic [14:0] dmaMap;
  logic [23:0] busAddr;
  logic busAen, busIoRd;
  logic [4:0] devIntr;
  logic [1:0] devDrq;
  logic [4:0] pinDack;
  logic [4:0]  ioSel;
  logic [1:0]  memSel, oenOut, devDack;
  logic [10:0] isaIrq;
  logic [4:0]  pinDrq;

  logic [4:0]  eIo;
  logic [1:0]  eMem, eOen, eDack;
  logic [10:0] eIrq;
  logic [4:0]  eDrq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ldr_router uut (.*);

  task automatic model();
    int lv[11] = '{3, 4, 5, 6, 7, 9, 10, 11, 12, 14, 15};
    bit act[5];
    int npins;
    eIo = '0; eMem = '0; eOen = '0; eDack = '0; eIrq = '0; eDrq = '0;
    if (!rst_n) return;
    npins = modeSel ? 5 : 3;
    for (int d = 0; d < 5; d++) begin
      int code, blk, a, b;
      act[d] = devActive[d] && (modeSel || d < 2);
      code = int'(ioSizeCode[d*3 +: 3]);
      a = int'(busAddr[15:0]);
      b = int'(ioBase[d*16 +: 16]);
      if (act[d] && !busAen && code <= 6) begin
        blk = 1 << code;
        eIo[d] = (a / blk) == (b / blk);
      end
      for (int k = 0; k < 11; k++)
        if (act[d] && int'(irqLevel[d*4 +: 4]) == lv[k] && devIntr[d]) eIrq[k] = 1'b1;
    end
    for (int d = 0; d < 2; d++) begin
      int hi, lo, up, ch;
      hi = int'(busAddr[23:8]);
      lo = int'(memBase[d*16 +: 16]);
      up = int'(memLimit[d*16 +: 16]);
      if (!modeSel && devActive[d] && hi >= lo && hi <= up) eMem[d] = 1'b1;
      ch = int'(dmaChan[d*3 +: 3]);
      if (act[d] && ch != 4)
        for (int p = 0; p < npins; p++)
          if (int'(dmaMap[p*3 +: 3]) == ch) begin
            if (devDrq[d]) eDrq[p] = 1'b1;
            if (pinDack[p]) eDack[d] = 1'b1;
          end
    end
    if (busIoRd) begin
      for (int k = 0; k < 2; k++) begin
        int c;
        c = (k == 0) ? int'(oenSel0) : int'(oenSel1);
        if (modeSel) begin
          if (c < 5 && eIo[c]) eOen[k] = 1'b1;
        end else if (k == 0) begin
          if ((c == 0 || c == 2) && eIo[0]) eOen[k] = 1'b1;
          if ((c == 1 || c == 2) && eIo[1]) eOen[k] = 1'b1;
        end
      end
    end
  endtask

  task automatic cmp(string tag, string grp, logic [10:0] act, logic [10:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, grp, act, exp);
    end
  endtask

  task automatic step(string tag);
    model();
    @(posedge clk);
    #1;
    cmp(tag, "ioSel R1", 11'(ioSel), 11'(eIo));
    cmp(tag, "memSel R3", 11'(memSel), 11'(eMem));
    cmp(tag, "oenOut R8", 11'(oenOut), 11'(eOen));
    cmp(tag, "isaIrq R5", isaIrq, eIrq);
    cmp(tag, "pinDrq R7", 11'(pinDrq), 11'(eDrq));
    cmp(tag, "devDack R7", 11'(devDack), 11'(eDack));
    @(negedge clk);
  endtask

  task automatic defaults();
    modeSel = 1'b1;
    devActive = 5'h1F;
    ioBase = {16'h0380, 16'h0360, 16'h0340, 16'h0320, 16'h0300};
    ioSizeCode = {3'd3, 3'd2, 3'd1, 3'd4, 3'd0};
    irqLevel = {4'd15, 4'd12, 4'd9, 4'd5, 4'd3};
    dmaChan = {3'd3, 3'd1};
    memBase = {16'h0D00, 16'h0C00};
    memLimit = {16'h0DFF, 16'h0C7F};
    oenSel0 = 3'd0; oenSel1 = 3'd1;
    dmaMap = {3'd7, 3'd6, 3'd5, 3'd3, 3'd1};
    busAddr = 24'h0; busAen = 1'b0; busIoRd = 1'b0;
    devIntr = '0; devDrq = '0; pinDack = '0;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    defaults();
    busAddr = 24'h000300; busIoRd = 1'b1; devIntr = '1; devDrq = '1; pinDack = '1;
    @(negedge clk);
    step("R10 reset");
    step("R10 reset");
    rst_n = 1'b1;
    step("R10 first cycle");

    defaults();
    for (int c = 0; c < 8; c++) begin
      ioSizeCode[2:0] = 3'(c);
      ioBase[15:0] = 16'h0340;
      busAddr = 24'h000340; step("R1 base");
      busAddr = 24'h000340 + 24'((1 << c) - 1); step("R1 last byte");
      busAddr = 24'h000340 + 24'(1 << c); step("R1 past block");
      busAddr = 24'h00033F; step("R1 below");
    end

    defaults();
    busAddr = 24'h000300; busIoRd = 1'b1; busAen = 1'b1; step("R2 aen high");
    busAen = 1'b0; step("R2 aen low");

    defaults();
    modeSel = 1'b0;
    foreach (memBase[i]) begin end
    busAddr = 24'h0C0000; step("R3 at base");
    busAddr = 24'h0C7FFF; step("R3 at limit");
    busAddr = 24'h0BFFFF; step("R3 below base");
    busAddr = 24'h0C8000; step("R3 above limit");
    busAddr = 24'h0DFF00; step("R3 dev1 limit");
    modeSel = 1'b1; busAddr = 24'h0C0000; step("R4 wide no mem");
    busAddr = 24'h000360; step("R4 dev3 io");
    busAddr = 24'h000383; step("R4 dev4 io");

    defaults();
    for (int l = 0; l < 16; l++) begin
      irqLevel[3:0] = 4'(l);
      devIntr = 5'b00001; step("R5 level sweep");
      devIntr = 5'b00000; step("R5 level low");
    end
    irqLevel = {4'd7, 4'd7, 4'd7, 4'd7, 4'd7};
    devIntr = 5'b10000; step("R5 shared line");

    defaults();
    devActive = 5'b00000; busAddr = 24'h000300; busIoRd = 1'b1;
    devIntr = '1; devDrq = '1; pinDack = '1; step("R6 all inactive");
    devActive = 5'b11110; step("R6 dev0 inactive");

    defaults();
    devDrq = 2'b01; step("R7 dev0 drq");
    pinDack = 5'b00001; step("R7 dack dev0");
    devDrq = 2'b10; pinDack = 5'b00010; step("R7 dev1");
    dmaChan = {3'd4, 3'd4}; devDrq = 2'b11; pinDack = '1; step("R7 channel 4 none");
    dmaMap = {3'd1, 3'd1, 3'd1, 3'd1, 3'd1}; dmaChan = {3'd4, 3'd1}; step("R7 duplicate map");

    defaults();
    busIoRd = 1'b1;
    for (int c = 0; c < 8; c++) begin
      oenSel0 = 3'(c); oenSel1 = 3'(7 - c);
      busAddr = 24'h000300; step("R8 wide dev0");
      busAddr = 24'h000325; step("R8 wide dev1");
      busAddr = 24'h000384; step("R8 wide dev4");
      modeSel = 1'b0;
      busAddr = 24'h000300; step("R8 narrow dev0");
      busAddr = 24'h000325; step("R8 narrow dev1");
      modeSel = 1'b1;
    end

    defaults();
    modeSel = 1'b0; busIoRd = 1'b1; oenSel1 = 3'd2;
    dmaMap = {3'd1, 3'd3, 3'd5, 3'd6, 3'd7};
    devIntr = '1; devDrq = '1; pinDack = 5'b11000;
    busAddr = 24'h000361; step("R9 narrow high devices");
    busAddr = 24'h000341; step("R9 narrow dev2 addr");

    for (int i = 0; i < 400; i++) begin
      int d;
      modeSel = 1'($urandom_range(0, 1));
      devActive = 5'($urandom);
      ioSizeCode = 15'($urandom);
      irqLevel = 20'($urandom);
      dmaChan = 6'($urandom);
      dmaMap = 15'($urandom);
      oenSel0 = 3'($urandom); oenSel1 = 3'($urandom);
      d = $urandom_range(0, 4);
      busAddr = {8'h0C, ioBase[d*16 +: 16]} + 24'($urandom_range(0, 70));
      busAen = ($urandom_range(0, 5) == 0);
      busIoRd = 1'($urandom);
      devIntr = 5'($urandom); devDrq = 2'($urandom); pinDack = 5'($urandom);
      step("random");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule